// File: doc/BRIEF.md
# Flash Erase/Write Protection and Suspend Control Registers

This block holds two byte-wide control registers that sit beside an on-chip flash controller. The CPU reaches them through a small byte bus: an address, a write strobe, write data and a read-data port that is decoded combinationally. The first register, the erase-control register, carries a suspend enable, a suspend request and a read-only status flag. The second register, the protection register, carries two region-enable bits and a sticky protection-error flag.

Two kinds of protection keep stray software writes from damaging stored code. First, every enable bit is guarded. It can only be set by a write of 0 to that bit followed, on the next write to the same register, by a write of 1. A single write of 0 clears it. Second, a decoder turns the enable bits and a CPU-rewrite-mode input into one erase/write permission line for each of five flash regions. A program or erase attempt aimed at a region that is not permitted sets the error flag.

The suspend path uses plain signals to talk to an external erase engine. The block drives an effective suspend request toward the engine. The engine answers with a suspend-done input, which sets the status flag. A resume write clears the flag and sends a one-cycle resume pulse to the engine. An erase-start input forces the flag low.

Top module: `flash_ctl_regs`

## Requirements
- R1: After reset the erase-control register reads 0x40 (status flag = 1, everything else 0). The protection register reads 0x01 (whole-user enable = 1). The suspend request, the resume pulse and the error flag are all 0.
- R2: Guarded bits are bit 0 of the erase-control register (suspend enable), and bits 0 (whole-user enable) and 1 (small-user enable) of the protection register. Each becomes 1 only on a write of 1 when the previous write to the same register wrote 0 to that bit. A write of 1 without that preceding 0 leaves the bit unchanged. Any write of 0 clears the bit. Writes to the other register do not disturb the arming.
- R3: Register addresses are 1 (erase-control) and 2 (protection). Every other address reads 0. Reserved bits read 0 and ignore writes of 1. The status flag (erase-control bit 6) and the error flag (protection bit 4) ignore writes of 1.
- R4: Erase-control bit 1 is the suspend request. Writing it stores the written value. The output susp_req_o equals request AND suspend enable.
- R5: When susp_req_o and susp_done_i are both 1 in a cycle, the status flag reads 1 from the next cycle on, unless R6 or R7 applies in that same cycle.
- R6: erase_start_i clears the status flag in the next cycle. It has priority over a set.
- R7: A write to erase-control with bit 1 = 0, made while the request bit and the status flag are both 1, clears the request and the flag. It also drives resume_o high for exactly the one following cycle. In every other case resume_o stays 0.
- R8: While rewrite_mode_i is 0, all five region enables are 0, whatever the register bits hold.
- R9: While rewrite_mode_i is 1, the region enables are as follows. Index 3 (data A) and index 4 (data B) are always 1. Index 2 (large user block) equals the whole-user enable. Indices 0 and 1 (small user blocks) are 1 only when both the whole-user and the small-user enables are 1.
- R10: prog_req_i with prog_region_i naming a disabled region, or an index of 5 or more, sets the error flag (protection bit 4) in the next cycle. A write to the protection register with bit 4 = 0 clears it. A set in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr_i | input | ADDR_W | Register address |
| bus_wr_i | input | 1 | Write strobe |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data for bus_addr_i |
| rewrite_mode_i | input | 1 | CPU-rewrite mode active |
| susp_done_i | input | 1 | Erase engine reports it has suspended |
| erase_start_i | input | 1 | Erase engine begins an erase |
| susp_req_o | output | 1 | Effective suspend request to the engine |
| resume_o | output | 1 | One-cycle resume pulse to the engine |
| prog_req_i | input | 1 | Erase/write attempt strobe |
| prog_region_i | input | IDX_W | Region index of the attempt |
| region_en_o | output | 5 | Per-region erase/write permission |

## Verification
The bench uses the default parameters: a 4-bit address, registers at 1 and 2, and a 3-bit region index. Because the index is wider than the five regions need, indices 5 to 7 can be driven, which exercises the out-of-range error path. The four-bit address space also leaves unmapped addresses 0 and 3 to 15 open to reads and writes. Random traffic spread over those addresses produces interleavings in which the other register is written between an arming 0 and a setting 1, as well as same-cycle set/clear collisions on both flags.

// File: rtl/flash_ctl_pkg.sv
package flash_ctl_pkg;
    localparam int DATA_W      = 8;
    localparam int NUM_REGIONS = 5;

    // erase-control register bit positions
    localparam int EC_EN_BIT   = 0;
    localparam int EC_REQ_BIT  = 1;
    localparam int EC_FLAG_BIT = 6;

    // protection register bit positions
    localparam int PR_ALL_BIT   = 0;
    localparam int PR_SMALL_BIT = 1;
    localparam int PR_ERR_BIT   = 4;

    typedef enum logic [2:0] {
        RGN_SMALL0 = 3'd0,
        RGN_SMALL1 = 3'd1,
        RGN_LARGE  = 3'd2,
        RGN_DATA_A = 3'd3,
        RGN_DATA_B = 3'd4
    } region_e;

    typedef struct packed {
        logic req;
        logic flag;
        logic resume;
    } susp_state_t;
endpackage

// File: rtl/flash_guard_bits.sv
module flash_guard_bits #(
    parameter int         N         = 1,
    parameter logic [N-1:0] RESET_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_i,
    input  logic [N-1:0] wdata_i,
    output logic [N-1:0] bits_o
);
    typedef struct packed {
        logic [N-1:0] bits;
        logic [N-1:0] armed;
    } guard_state_t;

    guard_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_i) begin
            for (int i = 0; i < N; i++) begin
                if (!wdata_i[i]) begin
                    st_d.bits[i] = 1'b0;
                end else if (st_q.armed[i]) begin
                    st_d.bits[i] = 1'b1;
                end
                st_d.armed[i] = ~wdata_i[i];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.bits  <= RESET_VAL;
            st_q.armed <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bits_o = st_q.bits;

    for (genvar g = 0; g < N; g++) begin : g_chk
        // R2: a rise needs a write of 1 in the cycle before
        assert_guard_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(bits_o[g]) |-> $past(wr_i && wdata_i[g]));
        // R2: a written 0 always clears
        assert_guard_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_i && !wdata_i[g]) |=> !bits_o[g]);
        // R2: without a write the bit holds
        assert_guard_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
            !wr_i |=> $stable(bits_o[g]));
    end
endmodule

// File: rtl/flash_susp_ctrl.sv
module flash_susp_ctrl
    import flash_ctl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic wr_i,
    input  logic wreq_i,
    input  logic susp_done_i,
    input  logic erase_start_i,
    output logic req_o,
    output logic flag_o,
    output logic resume_o,
    output logic susp_req_o
);
    susp_state_t st_d, st_q;
    logic        eff_req;

    assign eff_req = st_q.req & en_i;

    always_comb begin
        st_d        = st_q;
        st_d.resume = wr_i & ~wreq_i & st_q.req & st_q.flag;
        if (wr_i) begin
            st_d.req = wreq_i;
        end
        if (erase_start_i) begin
            st_d.flag = 1'b0;
        end else if (st_d.resume) begin
            st_d.flag = 1'b0;
        end else if (eff_req && susp_done_i) begin
            st_d.flag = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.req    <= 1'b0;
            st_q.flag   <= 1'b1;
            st_q.resume <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign req_o      = st_q.req;
    assign flag_o     = st_q.flag;
    assign resume_o   = st_q.resume;
    assign susp_req_o = eff_req;

    assert_flag_rise_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_o) |-> $past(susp_req_o && susp_done_i));
    assert_start_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        erase_start_i |=> !flag_o);
    assert_resume_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        resume_o |=> !resume_o);
    assert_resume_drops_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        resume_o |-> (!flag_o && !req_o));
endmodule

// File: rtl/flash_region_decode.sv
module flash_region_decode
    import flash_ctl_pkg::*;
(
    input  logic                   rw_i,
    input  logic                   all_i,
    input  logic                   small_i,
    output logic [NUM_REGIONS-1:0] en_o
);
    always_comb begin
        for (int r = 0; r < NUM_REGIONS; r++) begin
            unique case (region_e'(r))
                RGN_SMALL0, RGN_SMALL1: en_o[r] = rw_i & all_i & small_i;
                RGN_LARGE:              en_o[r] = rw_i & all_i;
                RGN_DATA_A, RGN_DATA_B: en_o[r] = rw_i;
                default:                en_o[r] = 1'b0;
            endcase
        end
    end

    always_comb begin
        if (!rw_i) begin
            assert_rw_off_R8: assert (en_o == '0);
        end
        if (en_o[RGN_SMALL0] || en_o[RGN_SMALL1]) begin
            assert_small_needs_large_R9: assert (en_o[RGN_LARGE]);
        end
    end
endmodule

// File: rtl/flash_ctl_regs.sv
module flash_ctl_regs
    import flash_ctl_pkg::*;
#(
    parameter int ADDR_W   = 4,
    parameter int EC_ADDR  = 1,
    parameter int PR_ADDR  = 2,
    parameter int IDX_W    = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [ADDR_W-1:0]      bus_addr_i,
    input  logic                   bus_wr_i,
    input  logic [DATA_W-1:0]      bus_wdata_i,
    output logic [DATA_W-1:0]      bus_rdata_o,
    input  logic                   rewrite_mode_i,
    input  logic                   susp_done_i,
    input  logic                   erase_start_i,
    output logic                   susp_req_o,
    output logic                   resume_o,
    input  logic                   prog_req_i,
    input  logic [IDX_W-1:0]       prog_region_i,
    output logic [NUM_REGIONS-1:0] region_en_o
);
    localparam int EXT_W = 1 << IDX_W;

    typedef struct packed {
        logic err;
    } top_state_t;

    top_state_t st_d, st_q;

    logic       wr_ec, wr_pr;
    logic       susp_en, req_bit, flag_bit;
    logic [1:0] prot_bits;
    logic [EXT_W-1:0] en_ext;
    logic       target_ok;

    assign wr_ec = bus_wr_i && (bus_addr_i == ADDR_W'(EC_ADDR));
    assign wr_pr = bus_wr_i && (bus_addr_i == ADDR_W'(PR_ADDR));

    flash_guard_bits #(.N(1), .RESET_VAL(1'b0)) u_ec_guard (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (wr_ec),
        .wdata_i (bus_wdata_i[EC_EN_BIT]),
        .bits_o  (susp_en)
    );

    flash_guard_bits #(.N(2), .RESET_VAL(2'b01)) u_pr_guard (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (wr_pr),
        .wdata_i ({bus_wdata_i[PR_SMALL_BIT], bus_wdata_i[PR_ALL_BIT]}),
        .bits_o  (prot_bits)
    );

    flash_susp_ctrl u_susp (
        .clk           (clk),
        .rst_n         (rst_n),
        .en_i          (susp_en),
        .wr_i          (wr_ec),
        .wreq_i        (bus_wdata_i[EC_REQ_BIT]),
        .susp_done_i   (susp_done_i),
        .erase_start_i (erase_start_i),
        .req_o         (req_bit),
        .flag_o        (flag_bit),
        .resume_o      (resume_o),
        .susp_req_o    (susp_req_o)
    );

    flash_region_decode u_rgn (
        .rw_i    (rewrite_mode_i),
        .all_i   (prot_bits[0]),
        .small_i (prot_bits[1]),
        .en_o    (region_en_o)
    );

    assign en_ext    = EXT_W'(region_en_o);
    assign target_ok = (int'(prog_region_i) < NUM_REGIONS) && en_ext[prog_region_i];

    always_comb begin
        st_d = st_q;
        if (prog_req_i && !target_ok) begin
            st_d.err = 1'b1;
        end else if (wr_pr && !bus_wdata_i[PR_ERR_BIT]) begin
            st_d.err = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.err <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        bus_rdata_o = '0;
        if (bus_addr_i == ADDR_W'(EC_ADDR)) begin
            bus_rdata_o[EC_EN_BIT]   = susp_en;
            bus_rdata_o[EC_REQ_BIT]  = req_bit;
            bus_rdata_o[EC_FLAG_BIT] = flag_bit;
        end else if (bus_addr_i == ADDR_W'(PR_ADDR)) begin
            bus_rdata_o[PR_ALL_BIT]   = prot_bits[0];
            bus_rdata_o[PR_SMALL_BIT] = prot_bits[1];
            bus_rdata_o[PR_ERR_BIT]   = st_q.err;
        end
    end

    assert_err_rise_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.err) |-> $past(prog_req_i));
    assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.err && !wr_pr) |=> st_q.err);
    assert_req_gated_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ec && !bus_wdata_i[EC_EN_BIT]) |=> !susp_req_o);
endmodule

// File: tb/flash_ctl_regs_bench.sv
`timescale 1ns/1ps
module flash_ctl_regs_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] addr = '0;
    logic       wr = 1'b0;
    logic [7:0] wd = '0;
    logic [7:0] rd;
    logic       rw = 1'b0, done = 1'b0, start = 1'b0, prog = 1'b0;
    logic [2:0] idx = '0;
    logic       sreq, resume;
    logic [4:0] ren;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    // model state
    bit m_en, m_req, m_flag, m_resume, m_all, m_small, m_err;
    bit a_en, a_all, a_small;

    always #5 clk = ~clk;

    flash_ctl_regs u_flash_ctl_regs (
        .clk(clk), .rst_n(rst_n), .bus_addr_i(addr), .bus_wr_i(wr),
        .bus_wdata_i(wd), .bus_rdata_o(rd), .rewrite_mode_i(rw),
        .susp_done_i(done), .erase_start_i(start), .susp_req_o(sreq),
        .resume_o(resume), .prog_req_i(prog), .prog_region_i(idx),
        .region_en_o(ren)
    );

    function automatic logic [4:0] exp_ren(bit r, bit al, bit sm);
        return r ? {1'b1, 1'b1, al, al & sm, al & sm} : 5'b0;
    endfunction

    function automatic logic [7:0] exp_rd(logic [3:0] a);
        if (a == 4'd1) return {1'b0, m_flag, 4'b0, m_req, m_en};
        if (a == 4'd2) return {3'b0, m_err, 2'b0, m_small, m_all};
        return 8'h00;
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        m_en = 0; m_req = 0; m_flag = 1; m_resume = 0;
        m_all = 1; m_small = 0; m_err = 0;
        a_en = 0; a_all = 0; a_small = 0;
    endtask

    task automatic model_edge();
        bit w1, w2, n_res, n_flag, n_err, ok;
        logic [4:0] e;
        w1 = wr && addr == 4'd1;
        w2 = wr && addr == 4'd2;
        e  = exp_ren(rw, m_all, m_small);
        ok = (idx < 3'd5) && e[idx];
        n_res = w1 && !wd[1] && m_req && m_flag;
        n_flag = m_flag;
        if (start) n_flag = 0;
        else if (n_res) n_flag = 0;
        else if (m_req && m_en && done) n_flag = 1;
        n_err = m_err;
        if (prog && !ok) n_err = 1;
        else if (w2 && !wd[4]) n_err = 0;
        if (w1) begin
            if (!wd[0]) m_en = 0; else if (a_en) m_en = 1;
            a_en = !wd[0];
            m_req = wd[1];
        end
        if (w2) begin
            if (!wd[0]) m_all = 0; else if (a_all) m_all = 1;
            if (!wd[1]) m_small = 0; else if (a_small) m_small = 1;
            a_all = !wd[0];
            a_small = !wd[1];
        end
        m_flag = n_flag; m_resume = n_res; m_err = n_err;
    endtask

    task automatic compare_all();
        logic [7:0] r1, r2;
        // outputs that depend on inputs still held from this cycle
        check(rw ? "R9 region enables" : "R8 region enables", ren, exp_ren(rw, m_all, m_small));
        check("R4 susp_req_o", sreq, m_req & m_en);
        check("R7 resume_o", resume, m_resume);
        wr = 0; prog = 0; start = 0; done = 0;
        addr = 4'd1; #1; r1 = rd;
        addr = 4'd2; #1; r2 = rd;
        check("R2 suspend enable", r1[0], m_en);
        check("R5 status flag", r1[6], m_flag);
        check("R3 erase-control readback", r1, exp_rd(4'd1));
        check("R2 whole-user enable", r2[0], m_all);
        check("R2 small-user enable", r2[1], m_small);
        check("R10 error flag", r2[4], m_err);
        check("R3 protection readback", r2, exp_rd(4'd2));
        addr = 4'd0; #1; check("R3 unmapped read", rd, 8'h00);
        addr = 4'd3; #1; check("R3 unmapped read", rd, 8'h00);
    endtask

    task automatic step(logic [3:0] a, logic w, logic [7:0] d, logic r,
                        logic dn, logic st, logic p, logic [2:0] i);
        addr = a; wr = w; wd = d; rw = r; done = dn; start = st; prog = p; idx = i;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare_all();
    endtask

    initial begin
        #2_000_000;
        if (!finished) begin
            finished = 1'b1;
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        model_reset();
        repeat (3) @(negedge clk);
        // R1: reset state
        addr = 4'd1; #1; check("R1 erase-control reset", rd, 8'h40);
        addr = 4'd2; #1; check("R1 protection reset", rd, 8'h01);
        check("R1 susp_req_o reset", sreq, 1'b0);
        check("R1 resume_o reset", resume, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: a 1 without arming leaves enable clear
        step(4'd1, 1, 8'h01, 1, 0, 0, 0, 0);
        check("R2 unarmed set ignored", m_en, 1'b0);
        // arm then set
        step(4'd1, 1, 8'h00, 1, 0, 0, 0, 0);
        step(4'd2, 1, 8'h01, 1, 0, 0, 0, 0);   // other register between: arming kept
        step(4'd1, 1, 8'h01, 1, 0, 0, 0, 0);
        check("R2 armed set", m_en, 1'b1);
        // R3: writes of 1 to reserved / read-only bits
        step(4'd1, 1, 8'hFD, 1, 0, 0, 0, 0);
        step(4'd3, 1, 8'hFF, 1, 0, 0, 0, 0);
        // small-user arming sequence -> small regions enabled (R9)
        step(4'd2, 1, 8'h11, 1, 0, 0, 0, 0);   // bit1=0 arms small, bit0 stays
        step(4'd2, 1, 8'h03, 1, 0, 0, 0, 0);
        check("R9 small blocks enabled", ren, 5'b11111);
        // R8: rewrite mode off
        step(4'd0, 0, 8'h00, 0, 0, 0, 0, 0);
        // R10: attempt to a disabled region while rw=0
        step(4'd0, 0, 8'h00, 0, 0, 0, 1, 3);
        check("R10 error after disabled attempt", m_err, 1'b1);
        // R10: same-cycle set wins over clear
        step(4'd2, 1, 8'h03, 1, 0, 0, 1, 6);
        step(4'd2, 1, 8'h03, 1, 0, 0, 0, 0);
        check("R10 error cleared", m_err, 1'b0);
        // R5: suspend handshake (enable is set)
        step(4'd1, 1, 8'h03, 1, 0, 1, 0, 0);   // set request, erase starts
        check("R6 erase start clears flag", m_flag, 1'b0);
        step(4'd0, 0, 8'h00, 1, 1, 0, 0, 0);
        check("R5 flag set by done", m_flag, 1'b1);
        // R7: resume
        step(4'd1, 1, 8'h01, 1, 0, 0, 0, 0);
        check("R7 resume pulse", m_resume, 1'b1);
        step(4'd0, 0, 8'h00, 1, 0, 0, 0, 0);
        check("R7 resume one cycle", m_resume, 1'b0);
        // R4: request without enable
        step(4'd1, 1, 8'h02, 1, 1, 0, 0, 0);
        check("R4 request without enable", m_req & m_en, 1'b0);
        // R6 vs R5 collision
        step(4'd1, 1, 8'h03, 1, 0, 1, 0, 0);
        step(4'd1, 1, 8'h02, 1, 1, 1, 0, 0);
        check("R6 start beats done", m_flag, 1'b0);

        // constrained random phase
        for (int n = 0; n < 4000; n++) begin
            logic [3:0] a;
            logic [7:0] d;
            a = 4'($urandom_range(0, 4));
            d = 8'($urandom);
            if ($urandom_range(0, 3) != 0) d = d & 8'h13;
            step(a, $urandom_range(0, 1) == 1, d, $urandom_range(0, 4) != 0,
                 $urandom_range(0, 2) == 0, $urandom_range(0, 19) == 0,
                 $urandom_range(0, 4) == 0, 3'($urandom_range(0, 7)));
        end

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule